// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block is a purely combinational adder for two 16-bit operands and a carry-in. It does not let the carry ripple from bit to bit. The operand is split into four 4-bit sections. Each section forms a per-bit generate term (a AND b) and propagate term (a XOR b). From these it works out its internal carries as flat sums of products. It also reduces its bits to one section generate and one section propagate.

A second lookahead unit of the same kind takes the four section pairs and the carry-in. It works out the carry into each section. It also produces a whole-word generate/propagate pair. The carry-out is built from that word pair and the carry-in. The word pair is also brought out, so that a further lookahead level can chain several of these adders into a wider one.

The combining rule for generate/propagate pairs is (g,p)·(g',p') = (g | p&g', p&p'), where the first pair is the more significant one. This rule is associative but not commutative. All reductions therefore keep the high-to-low order of their operands.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals (a + b + cin) modulo 2^16 for every input combination.
- R2: `cout` equals bit 16 of the 17-bit result of a + b + cin.
- R3: `grp_g` is 1 exactly when a + b, taken with a carry-in of 0, produces a carry out of bit 15.
- R4: `grp_p` is 1 exactly when every bit of a XOR b is 1, so that an incoming carry would pass through all 16 bits.
- R5: When `grp_p` is 1, `sum` is all ones if cin is 0 and all zeros if cin is 1, and `cout` equals cin. This is the longest carry path, running through all four sections.
- R6: `grp_g` and `grp_p` are never 1 at the same time.
- R7: The carry entering each 4-bit section equals the carry out of the lower bits plus cin. In particular, a carry made in section k and passed on by sections above it reaches the right sum bits.
- R8: The outputs depend only on the present inputs, with no register, reset or clock involved. A new input shows on the outputs with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| grp_g | output | 1 | Whole-word generate, for chaining to a further lookahead level |
| grp_p | output | 1 | Whole-word propagate, for chaining to a further lookahead level |

## Verification
The bench goes after operands whose XOR is all ones, with either carry-in, and also after partial chains. In a partial chain, one section generates a carry and only the sections above it pass it on. A design that swapped the operands of the combining rule, or that ANDed the wrong propagate terms, would drop or invent a carry several sections up. That error shows as a wrong upper nibble in `sum`. A wrong word pair shows as `grp_g` and `grp_p` both set, or as a carry-out that disagrees with the 17-bit result. Random operands, some with bits weighted toward the propagate pattern, cover the rest.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // generate/propagate pair for one bit or one group of bits
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // combine a more significant pair (hi) with a less significant one (lo);
    // the order of the operands matters
    function automatic gp_t gp_dot(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // per-bit pair from two operand bits; XOR propagate is shared with the sum
    function automatic gp_t gp_bit(logic x, logic y);
        gp_t r;
        r.g = x & y;
        r.p = x ^ y;
        return r;
    endfunction

endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int N = 4
) (
    input  gp_t [N-1:0] gp_in,
    input  logic        cin,
    output logic [N-1:0] carry,
    output gp_t          grp
);

    // carry into position i as a flat sum of products of g, p and cin
    always_comb begin
        logic acc;
        logic run;
        carry[0] = cin;
        for (int i = 1; i < N; i++) begin
            acc = 1'b0;
            run = 1'b1;
            for (int j = i - 1; j >= 0; j--) begin
                acc = acc | (run & gp_in[j].g);
                run = run & gp_in[j].p;
            end
            carry[i] = acc | (run & cin);
        end
    end

    // group pair: fold from the most significant element downward
    always_comb begin
        gp_t f;
        f = gp_in[N-1];
        for (int k = N - 2; k >= 0; k--) begin
            f = gp_dot(f, gp_in[k]);
        end
        grp = f;
    end

endmodule

// File: rtl/cla_section.sv
module cla_section
    import cla_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output gp_t          grp
);

    gp_t [W-1:0]  bit_gp;
    logic [W-1:0] bit_c;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_gp[i] = gp_bit(a[i], b[i]);
        assign sum[i]    = bit_gp[i].p ^ bit_c[i];
    end

    cla_lookahead #(.N(W)) u_la (
        .gp_in (bit_gp),
        .cin   (cin),
        .carry (bit_c),
        .grp   (grp)
    );

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
    import cla_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEC_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              grp_g,
    output logic              grp_p
);

    localparam int NSEC = DATA_W / SEC_W;

    gp_t [NSEC-1:0]  sec_gp;
    logic [NSEC-1:0] sec_c;
    gp_t             word_gp;

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        cla_section #(.W(SEC_W)) u_sec (
            .a   (a[k*SEC_W +: SEC_W]),
            .b   (b[k*SEC_W +: SEC_W]),
            .cin (sec_c[k]),
            .sum (sum[k*SEC_W +: SEC_W]),
            .grp (sec_gp[k])
        );
    end

    // second level: same lookahead unit over section pairs
    cla_lookahead #(.N(NSEC)) u_top (
        .gp_in (sec_gp),
        .cin   (cin),
        .carry (sec_c),
        .grp   (word_gp)
    );

    assign grp_g = word_gp.g;
    assign grp_p = word_gp.p;
    assign cout  = word_gp.g | (word_gp.p & cin);

endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
    parameter int DATA_W = 16,
    parameter int SEC_W  = 4
) (
    input logic [DATA_W-1:0]        a,
    input logic [DATA_W-1:0]        b,
    input logic                     cin,
    input logic [DATA_W-1:0]        sum,
    input logic                     cout,
    input logic                     grp_g,
    input logic                     grp_p,
    input logic [DATA_W/SEC_W-1:0]  sec_c
);

    localparam int NSEC = DATA_W / SEC_W;

    logic [DATA_W:0] full;
    logic [DATA_W:0] nocarry;
    assign full    = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    assign nocarry = {1'b0, a} + {1'b0, b};

    always_comb begin
        // R1
        sum_value_chk: assert (sum == full[DATA_W-1:0])
            else $error("sum mismatch");
        // R2
        carry_out_chk: assert (cout == full[DATA_W])
            else $error("cout mismatch");
        // R3
        word_gen_chk: assert (grp_g == nocarry[DATA_W])
            else $error("grp_g mismatch");
        // R5
        long_chain_chk: assert (!grp_p || ((sum == {DATA_W{~cin}}) && (cout == cin)))
            else $error("propagate chain mismatch");
        // R6
        gp_excl_chk: assert (!(grp_g && grp_p))
            else $error("generate and propagate both set");
    end

    always_comb begin
        logic [DATA_W:0] mask;
        logic [DATA_W:0] part;
        for (int k = 0; k < NSEC; k++) begin
            mask = ({{DATA_W{1'b0}}, 1'b1} << (k*SEC_W)) - 1'b1;
            part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{DATA_W{1'b0}}, cin};
            // R7
            sec_carry_chk: assert (sec_c[k] == part[k*SEC_W])
                else $error("section carry mismatch");
        end
    end

endmodule

bind cla_adder16 cla_adder16_chk #(.DATA_W(DATA_W), .SEC_W(SEC_W)) u_chk (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .grp_g (grp_g),
    .grp_p (grp_p),
    .sec_c (sec_c)
);

// File: tb/cla_adder16_tb.sv
`timescale 1ns/1ps
module cla_adder16_tb;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic [DW-1:0] a = '0;
    logic [DW-1:0] b = '0;
    logic          cin = 1'b0;
    logic [DW-1:0] sum;
    logic          cout, grp_g, grp_p;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cla_adder16 u_dut (
        .a(a), .b(b), .cin(cin),
        .sum(sum), .cout(cout), .grp_g(grp_g), .grp_p(grp_p)
    );

    function automatic logic [DW:0] ref_add(logic [DW-1:0] x, logic [DW-1:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, c};
    endfunction

    function automatic logic ref_gen(logic [DW-1:0] x, logic [DW-1:0] y);
        logic [DW:0] t;
        t = {1'b0, x} + {1'b0, y};
        return t[DW];
    endfunction

    function automatic logic ref_prop(logic [DW-1:0] x, logic [DW-1:0] y);
        return &(x ^ y);
    endfunction

    task automatic check1(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, act, exp);
        end
    endtask

    // apply at posedge, sample at the following negedge (no cycle delay: R8)
    task automatic apply(logic [DW-1:0] x, logic [DW-1:0] y, logic c, string tag);
        logic [DW:0] r;
        @(posedge clk);
        a = x; b = y; cin = c;
        @(negedge clk);
        r = ref_add(x, y, c);
        check1({tag, " R1 sum"},  sum, r[DW-1:0]);
        check1({tag, " R2 cout"}, {15'b0, cout}, {15'b0, r[DW]});
        check1({tag, " R3 grp_g"}, {15'b0, grp_g}, {15'b0, ref_gen(x, y)});
        check1({tag, " R4 grp_p"}, {15'b0, grp_p}, {15'b0, ref_prop(x, y)});
        check1({tag, " R6 excl"}, {15'b0, grp_g & grp_p}, 16'h0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R8: zero inputs settle to zero outputs at once
        apply(16'h0000, 16'h0000, 1'b0, "zero");
        // R5: full propagate chain through all four sections
        apply(16'hFFFF, 16'h0000, 1'b1, "R5 chain");
        apply(16'hAAAA, 16'h5555, 1'b1, "R5 chain");
        apply(16'h0F0F, 16'hF0F0, 1'b0, "R5 chain");
        apply(16'h1234, 16'hEDCB, 1'b1, "R5 chain");
        // R7: carry generated in section k, passed by sections above
        apply(16'hFFF8, 16'h0008, 1'b0, "R7 sec0");
        apply(16'hFF80, 16'h0080, 1'b0, "R7 sec1");
        apply(16'hF800, 16'h0800, 1'b0, "R7 sec2");
        apply(16'h000F, 16'h0000, 1'b1, "R7 nib");
        apply(16'h00FF, 16'h0000, 1'b1, "R7 byte");
        // R3 and R6 extremes
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R3 max");
        apply(16'h8000, 16'h8000, 1'b0, "R3 msb");
        apply(16'h7FFF, 16'h0001, 1'b0, "R1 mid");
        for (int i = 0; i < 3000; i++) begin
            logic [DW-1:0] x, y;
            x = DW'($urandom);
            y = DW'($urandom);
            if (i % 4 == 0) y = ~x ^ (DW'(1) << (i % DW));
            if (i % 8 == 1) y = ~x;
            apply(x, y, 1'($urandom), "R1 rand");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog timeout actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule